// File: doc/BRIEF.md
# Programmable-Priority Interrupt Winner Resolver

This block turns a software-programmed priority table into a single status word naming the most urgent pending fast interrupt (FIQ) and the most urgent pending normal interrupt (IRQ). The table has one 32-bit entry per priority slot. Bit 31 of an entry marks it as in use, and bits 5:0 name a source. Slot 0 is the most urgent. Three per-source vectors come from neighbouring logic: pending, enable and route. A route bit of 1 sends that source to the FIQ class, and 0 sends it to the IRQ class.

The resolver picks the two winners independently. Each winner is reported in its own 16-bit half of a 32-bit word. The word is registered and is recomputed on every clock from the inputs present at that edge. A register read path elsewhere can return it directly. The block holds no table storage, does no bus decoding and drives no interrupt lines.

The status interface is a plain level-valued status word with no handshake. There is no valid/ready and no back-pressure: the word is always valid after reset and is overwritten every cycle.

Top module: `prio_winner_resolver`

## Requirements
- R1: During reset and whenever no entry qualifies in either class, the status word is 0x003F003F. Each half then has its flag clear and its id field at all ones.
- R2: An entry qualifies only if its bit 31 is 1 and its id (bits 5:0) is below NUM_SRC (40). Bits 30:6 of an entry have no effect on the result.
- R3: The source named by a qualifying entry is active only when both its pending bit and its enable bit are 1.
- R4: Among qualifying entries with active sources in the same class, the one at the lowest table slot wins. Two slots may name the same source; no error results and the lower slot wins.
- R5: A source with route bit 1 competes in the FIQ class. The FIQ winner sets bit 15, places its id in bits 5:0 and clears bits 14:6.
- R6: A source with route bit 0 competes in the IRQ class. The IRQ winner sets bit 31, places its id in bits 21:16 and clears bits 30:22.
- R7: Each half depends only on its own class. An empty class reports 0x003F in its half whatever the other class holds.
- R8: The status word changes only at a clock edge and reflects the inputs sampled at that edge, one cycle after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prio_table_i | input | NUM_SRC*32 | Priority table; slot k occupies bits 32k+31:32k |
| pend_i | input | NUM_SRC | Per-source pending bits |
| enab_i | input | NUM_SRC | Per-source enable bits |
| fiq_sel_i | input | NUM_SRC | Per-source route: 1 = FIQ class, 0 = IRQ class |
| status_o | output | 32 | Registered winner word (IRQ half high, FIQ half low) |

## Verification
The hardest cases to reach from the ports are these:
- A slot at a low index that must be skipped, because it is marked in use but names an id of 40 to 63, while a later, lawful slot must win.
- Two slots naming one source.
- A cycle where both classes have winners at once.

Directed tables place out-of-range ids and duplicate ids ahead of valid ones. A mixed route vector is set up so that both halves resolve in the same cycle. Long runs of random tables, including random junk in the unused entry bits, then exercise the same ordering rules against a behavioural reference model that is compared on every clock.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
  localparam int ENTRY_W = 32;
  localparam int ID_W    = 6;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 2 * HALF_W;

  localparam logic [HALF_W-1:0] EMPTY_HALF = {1'b0, {(HALF_W-1-ID_W){1'b0}}, {ID_W{1'b1}}};
  localparam logic [WORD_W-1:0] EMPTY_WORD = {EMPTY_HALF, EMPTY_HALF};

  function automatic logic [HALF_W-1:0] fmt_half(input logic found, input logic [ID_W-1:0] id);
    return {found, {(HALF_W-1-ID_W){1'b0}}, id};
  endfunction
endpackage

// File: rtl/prio_entry_decode.sv
module prio_entry_decode
  import prio_res_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [NUM_SRC-1:0] active_i,
  input  logic [NUM_SRC-1:0] route_i,
  output logic               fiq_hit_o,
  output logic               irq_hit_o,
  output logic [ID_W-1:0]    id_o
);
  localparam int SPAN = 1 << ID_W;
  localparam logic [ID_W:0] LIMIT = NUM_SRC[ID_W:0];

  logic [SPAN-1:0] act_ext;
  logic [SPAN-1:0] rte_ext;
  logic            in_use;
  logic            usable;
  logic            entry_unused;

  assign act_ext      = SPAN'(active_i);
  assign rte_ext      = SPAN'(route_i);
  assign id_o         = entry_i[ID_W-1:0];
  assign in_use       = entry_i[ENTRY_W-1];
  assign usable       = in_use && ({1'b0, id_o} < LIMIT);
  assign entry_unused = ^entry_i[ENTRY_W-2:ID_W];

  assign fiq_hit_o = usable && act_ext[id_o] && rte_ext[id_o];
  assign irq_hit_o = usable && act_ext[id_o] && !rte_ext[id_o];
endmodule

// File: rtl/prio_first_pick.sv
module prio_first_pick
  import prio_res_pkg::*;
#(
  parameter int NUM_SLOT = 40
) (
  input  logic [NUM_SLOT-1:0]      hit_i,
  input  logic [NUM_SLOT*ID_W-1:0] ids_i,
  output logic                     found_o,
  output logic [ID_W-1:0]          id_o
);
  always_comb begin
    found_o = 1'b0;
    id_o    = {ID_W{1'b1}};
    for (int k = NUM_SLOT - 1; k >= 0; k--) begin
      if (hit_i[k]) begin
        found_o = 1'b1;
        id_o    = ids_i[k*ID_W +: ID_W];
      end
    end
  end
endmodule

// File: rtl/prio_winner_resolver.sv
module prio_winner_resolver
  import prio_res_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SRC*ENTRY_W-1:0] prio_table_i,
  input  logic [NUM_SRC-1:0]         pend_i,
  input  logic [NUM_SRC-1:0]         enab_i,
  input  logic [NUM_SRC-1:0]         fiq_sel_i,
  output logic [WORD_W-1:0]          status_o
);
  logic [NUM_SRC-1:0]      active;
  logic [NUM_SRC-1:0]      fiq_hit;
  logic [NUM_SRC-1:0]      irq_hit;
  logic [NUM_SRC*ID_W-1:0] slot_ids;
  logic                    fiq_found;
  logic                    irq_found;
  logic [ID_W-1:0]         fiq_id;
  logic [ID_W-1:0]         irq_id;
  logic [WORD_W-1:0]       status_d;

  assign active = pend_i & enab_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
    prio_entry_decode #(.NUM_SRC(NUM_SRC)) u_dec (
      .entry_i   (prio_table_i[s*ENTRY_W +: ENTRY_W]),
      .active_i  (active),
      .route_i   (fiq_sel_i),
      .fiq_hit_o (fiq_hit[s]),
      .irq_hit_o (irq_hit[s]),
      .id_o      (slot_ids[s*ID_W +: ID_W])
    );
  end

  prio_first_pick #(.NUM_SLOT(NUM_SRC)) u_pick_fiq (
    .hit_i   (fiq_hit),
    .ids_i   (slot_ids),
    .found_o (fiq_found),
    .id_o    (fiq_id)
  );

  prio_first_pick #(.NUM_SLOT(NUM_SRC)) u_pick_irq (
    .hit_i   (irq_hit),
    .ids_i   (slot_ids),
    .found_o (irq_found),
    .id_o    (irq_id)
  );

  assign status_d = {fmt_half(irq_found, irq_id), fmt_half(fiq_found, fiq_id)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= EMPTY_WORD;
    else         status_o <= status_d;
  end
endmodule

// File: rtl/prio_winner_resolver_chk.sv
module prio_winner_resolver_chk
  import prio_res_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_SRC*ENTRY_W-1:0] prio_table_i,
  input logic [NUM_SRC-1:0]         pend_i,
  input logic [NUM_SRC-1:0]         enab_i,
  input logic [NUM_SRC-1:0]         fiq_sel_i,
  input logic [WORD_W-1:0]          status_o
);
  localparam int LO_FLAG = HALF_W - 1;
  localparam int HI_FLAG = WORD_W - 1;

  logic [NUM_SRC-1:0] in_use_bits;
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_use
    assign in_use_bits[s] = prio_table_i[s*ENTRY_W + ENTRY_W - 1];
  end

  p_empty_half_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[LO_FLAG] |-> status_o[HALF_W-1:0] == EMPTY_HALF);
  p_empty_top_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[HI_FLAG] |-> status_o[WORD_W-1:HALF_W] == EMPTY_HALF);
  p_no_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_use_bits == '0) |=> status_o == EMPTY_WORD);
  p_no_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enab_i == '0) |=> status_o == EMPTY_WORD);
  p_fiq_shape_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[LO_FLAG] |-> (status_o[LO_FLAG-1:ID_W] == '0) &&
                          (int'(status_o[ID_W-1:0]) < NUM_SRC));
  p_irq_shape_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[HI_FLAG] |-> (status_o[HI_FLAG-1:HALF_W+ID_W] == '0) &&
                          (int'(status_o[HALF_W+ID_W-1:HALF_W]) < NUM_SRC));
  p_all_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_sel_i == '0) |=> !status_o[LO_FLAG]);
  p_all_fiq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_sel_i == '1) |=> !status_o[HI_FLAG]);
endmodule

bind prio_winner_resolver prio_winner_resolver_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prio_table_i (prio_table_i),
  .pend_i       (pend_i),
  .enab_i       (enab_i),
  .fiq_sel_i    (fiq_sel_i),
  .status_o     (status_o)
);

// File: tb/tb_prio_winner_resolver.sv
`timescale 1ns/1ps
module tb_prio_winner_resolver;
  localparam int N = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       tbl [N];
  logic [N*32-1:0]   tbl_flat;
  logic [N-1:0]      pend = '0;
  logic [N-1:0]      enab = '0;
  logic [N-1:0]      route = '0;
  logic [31:0]       status;
  int                n_checks = 0;
  int                n_err = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) tbl_flat[i*32 +: 32] = tbl[i];

  prio_winner_resolver #(.NUM_SRC(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .prio_table_i(tbl_flat),
    .pend_i(pend), .enab_i(enab), .fiq_sel_i(route), .status_o(status)
  );

  function automatic logic [31:0] ref_word();
    logic [15:0] lo = 16'h003F;
    logic [15:0] hi = 16'h003F;
    bit got_f = 0;
    bit got_i = 0;
    for (int i = 0; i < N; i++) begin
      int id = int'(tbl[i][5:0]);
      if (tbl[i][31] && id < N && pend[id] && enab[id]) begin
        if (route[id] && !got_f) begin got_f = 1; lo = 16'h8000 | 16'(id); end
        if (!route[id] && !got_i) begin got_i = 1; hi = 16'h8000 | 16'(id); end
      end
    end
    return {hi, lo};
  endfunction

  task automatic check(string req, logic [31:0] exp);
    n_checks++;
    if (status !== exp) begin
      n_err++;
      $display("FAIL %s status=%h expected=%h at %0t", req, status, exp, $time);
    end
  endtask

  task automatic cycle_check(string req);
    @(negedge clk);
    check(req, ref_word());
  endtask

  task automatic clear_table();
    for (int i = 0; i < N; i++) tbl[i] = 32'h0;
  endtask

  task automatic identity_table();
    for (int i = 0; i < N; i++) tbl[i] = 32'h8000_0000 | 32'(i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] held;
    identity_table();
    pend = '1; enab = '1; route = 40'h00_F0F0_0F0F;
    // R1: reset value held while busy inputs are applied
    repeat (2) @(negedge clk);
    check("R1", 32'h003F003F);
    rst_n = 1'b1;
    cycle_check("R4");

    // R2: nothing in use, everything pending
    clear_table();
    cycle_check("R2");
    check("R2", 32'h003F003F);
    // R2: in-use slots naming ids 40..63 ahead of a lawful one
    for (int i = 0; i < 10; i++) tbl[i] = 32'h8000_0000 | 32'(40 + i * 2);
    tbl[10] = 32'h8000_0007;
    route = '0;
    cycle_check("R2");
    check("R2", 32'h8007003F);
    // R2: junk in bits 30:6 ignored
    tbl[10] = 32'hFFFF_FFC7;
    cycle_check("R2");
    check("R2", 32'h8007003F);

    // R6 / R5: single source, each route
    identity_table();
    pend = '0; pend[17] = 1'b1;
    route = '0;
    cycle_check("R6");
    check("R6", 32'h8011003F);
    route[17] = 1'b1;
    cycle_check("R5");
    check("R5", 32'h003F8011);

    // R3: pending without enable, enable without pending
    enab = '0;
    cycle_check("R3");
    check("R3", 32'h003F003F);
    enab = '1; pend = '0;
    cycle_check("R3");
    enab = '0; enab[5] = 1'b1; pend = '1;
    route = '0;
    cycle_check("R3");
    check("R3", 32'h8005003F);
    enab = '1;

    // R4: reversed table, lower slot wins
    for (int i = 0; i < N; i++) tbl[i] = 32'h8000_0000 | 32'(N - 1 - i);
    pend = '0; pend[3] = 1'b1; pend[30] = 1'b1;
    cycle_check("R4");
    check("R4", 32'h801E003F);
    // R4: duplicate ids
    clear_table();
    tbl[2] = 32'h8000_000C; tbl[5] = 32'h8000_000C; tbl[6] = 32'h8000_0003;
    pend = '0; pend[12] = 1'b1; pend[3] = 1'b1;
    cycle_check("R4");
    check("R4", 32'h800C003F);

    // R7: both classes at once, then independence
    identity_table();
    pend = '0; pend[9] = 1'b1; pend[20] = 1'b1; pend[33] = 1'b1;
    route = '0; route[20] = 1'b1; route[33] = 1'b1;
    cycle_check("R7");
    check("R7", 32'h80098014);
    pend[9] = 1'b0;
    cycle_check("R7");
    check("R7", 32'h003F8014);

    // R8: one-cycle latency, holds until the edge
    held = ref_word();
    pend = '0; pend[1] = 1'b1; route = '0;
    #1;
    check("R8", held);
    @(posedge clk); #1;
    check("R8", 32'h8001003F);
    @(negedge clk);

    // R4: random tables and vectors, checked every clock
    for (int it = 0; it < 400; it++) begin
      for (int i = 0; i < N; i++) begin
        tbl[i] = $urandom;
        tbl[i][31] = ($urandom_range(3) != 0);
        tbl[i][5:0] = 6'($urandom_range(63));
      end
      pend  = {$urandom, $urandom} >> 24;
      enab  = {$urandom, $urandom} >> 24;
      route = {$urandom, $urandom} >> 24;
      cycle_check("R4");
    end

    // R1: reset in mid-run
    identity_table(); pend = '1; enab = '1;
    rst_n = 1'b0;
    #1;
    check("R1", 32'h003F003F);
    @(negedge clk);
    check("R1", 32'h003F003F);
    rst_n = 1'b1;
    cycle_check("R1");

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule